// File: doc/BRIEF.md
# Video-Priority Memory Port Arbiter

This block sits in front of a shared SDRAM controller and decides which of three requesters owns the next memory burst: the system bus, an LCD refresh DMA channel and a VGA refresh DMA channel. Each requester has its own address input, request line, grant and per-beat acknowledge. Read data is returned to all of them on one shared data bus, and the acknowledge tells each requester which beats belong to it.

Every grant is one burst of eight halfword beats. Arbitration happens only at burst boundaries, or when the port is idle. At each such point a video channel always wins over the system bus, and LCD wins over VGA. The winning address is captured and held on the memory back-end interface for the whole burst. The back end reports each delivered halfword with a beat strobe.

A system-bus cycle that targets a slow non-SDRAM device is flagged by the bus and is never given the memory port. While such a cycle is stalled, video refresh keeps flowing.

Top module: `vid_mem_arbiter`

## Requirements
- R1: During and right after reset no grant is asserted and `mem_req` is low.
- R2: When no eligible request is pending at an arbitration point, the block stays idle with no grant and `mem_req` low.
- R3: At an arbitration point the winner is chosen as follows: LCD if `lcd_req` is high; otherwise VGA if `vga_req` is high; otherwise the system bus if `sys_req` and `sys_to_sdram` are both high. The grant rises one clock after that decision.
- R4: A granted burst lasts exactly 8 beats, counted as cycles with `mem_beat` high. The grant and `mem_addr` do not change before the 8th beat, whatever requests arrive in the meantime.
- R5: The owner's acknowledge is high in exactly the cycles where `mem_beat` is high, and in those cycles `rd_data` carries `mem_rdata`. Other requesters see no acknowledge.
- R6: `mem_addr` equals the owning requester's address, as sampled at the grant edge.
- R7: A system-bus request with `sys_to_sdram` low is never granted, and video bursts are served while it is held.
- R8: The clock edge that completes the 8th beat is itself an arbitration point, so a still-pending requester gets its next burst without an idle cycle.
- R9: Cycles without `mem_beat` inside a burst neither advance the burst nor produce acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_req | input | 1 | System-bus request |
| sys_to_sdram | input | 1 | System-bus cycle targets SDRAM |
| sys_addr | input | AW | System-bus address |
| sys_gnt | output | 1 | System bus owns the port |
| sys_ack | output | 1 | Beat acknowledge to system bus |
| lcd_req | input | 1 | LCD DMA request |
| lcd_addr | input | AW | LCD DMA address |
| lcd_gnt | output | 1 | LCD owns the port |
| lcd_ack | output | 1 | Beat acknowledge to LCD |
| vga_req | input | 1 | VGA DMA request |
| vga_addr | input | AW | VGA DMA address |
| vga_gnt | output | 1 | VGA owns the port |
| vga_ack | output | 1 | Beat acknowledge to VGA |
| rd_data | output | DW | Shared read data bus |
| mem_req | output | 1 | Burst in progress to back end |
| mem_addr | output | AW | Burst address to back end |
| mem_beat | input | 1 | Back end delivers one halfword |
| mem_rdata | input | DW | Back-end read data |

## Verification
Every combination of zero, one or two pending bursts on each of the three requesters is raised at the same moment. The order in which the bursts complete then has to match the fixed ranking, so a swapped priority or a lost re-grant shows up. A system-bus burst that is already running has a video request arrive in its middle, which shows whether a burst can be preempted. Back-to-back LCD bursts with a beat in every cycle must keep the grant high for exactly 16 cycles, which reveals any idle slot at the burst boundary. A beat pattern with gaps, and a held non-SDRAM system cycle, show that only real beats count and that slow cycles never take the port.

// File: rtl/vid_mem_arbiter.sv
module vid_mem_arbiter #(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int BEATS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_req,
  input  logic          sys_to_sdram,
  input  logic [AW-1:0] sys_addr,
  output logic          sys_gnt,
  output logic          sys_ack,
  input  logic          lcd_req,
  input  logic [AW-1:0] lcd_addr,
  output logic          lcd_gnt,
  output logic          lcd_ack,
  input  logic          vga_req,
  input  logic [AW-1:0] vga_addr,
  output logic          vga_gnt,
  output logic          vga_ack,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_beat,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  typedef enum logic [1:0] {OWN_NONE, OWN_SYS, OWN_LCD, OWN_VGA} own_t;

  own_t          owner, pick;
  logic [CW-1:0] beat_cnt;
  logic [AW-1:0] addr_q, pick_addr;

  wire last_beat = (owner != OWN_NONE) && mem_beat && (beat_cnt == CW'(BEATS-1));
  wire arb_point = (owner == OWN_NONE) || last_beat;

  always_comb begin
    pick      = OWN_NONE;
    pick_addr = addr_q;
    if (lcd_req) begin
      pick      = OWN_LCD;
      pick_addr = lcd_addr;
    end else if (vga_req) begin
      pick      = OWN_VGA;
      pick_addr = vga_addr;
    end else if (sys_req && sys_to_sdram) begin
      pick      = OWN_SYS;
      pick_addr = sys_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner    <= OWN_NONE;
      beat_cnt <= '0;
      addr_q   <= '0;
    end else if (arb_point) begin
      owner    <= pick;
      beat_cnt <= '0;
      addr_q   <= pick_addr;
    end else if (mem_beat) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  assign sys_gnt  = (owner == OWN_SYS);
  assign lcd_gnt  = (owner == OWN_LCD);
  assign vga_gnt  = (owner == OWN_VGA);
  assign sys_ack  = sys_gnt & mem_beat;
  assign lcd_ack  = lcd_gnt & mem_beat;
  assign vga_ack  = vga_gnt & mem_beat;
  assign mem_req  = (owner != OWN_NONE);
  assign mem_addr = addr_q;
  assign rd_data  = mem_rdata;

  assert_lcd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && lcd_req |=> lcd_gnt);

  assert_vga_over_sys_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && !lcd_req && vga_req |=> vga_gnt);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && !lcd_req && !vga_req && !sys_req |=> !mem_req);

  assert_burst_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !last_beat |=> $stable(mem_addr) && $stable({sys_gnt, lcd_gnt, vga_gnt}));

  assert_slow_never_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && !sys_to_sdram && !lcd_req && !vga_req |=> !sys_gnt);
endmodule

// File: tb/vid_mem_arbiter_bench.sv
`timescale 1ns/100ps
module vid_mem_arbiter_bench;
  localparam int AW = 20, DW = 16;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  int pend [3];
  logic sys_slow = 0;
  logic [AW-1:0] chan_addr [3];
  logic sys_gnt, sys_ack, lcd_gnt, lcd_ack, vga_gnt, vga_ack, mem_req;
  logic [DW-1:0] rd_data, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_beat = 0, gap_mode = 0, tog = 0;
  logic [2:0] bcnt;

  wire sys_req = (pend[0] > 0) || sys_slow;
  wire lcd_req = pend[1] > 0;
  wire vga_req = pend[2] > 0;

  vid_mem_arbiter #(.AW(AW), .DW(DW), .BEATS(8)) u_vid_mem_arbiter (
    .clk(clk), .rst_n(rst_n),
    .sys_req(sys_req), .sys_to_sdram(!sys_slow), .sys_addr(chan_addr[0]),
    .sys_gnt(sys_gnt), .sys_ack(sys_ack),
    .lcd_req(lcd_req), .lcd_addr(chan_addr[1]), .lcd_gnt(lcd_gnt), .lcd_ack(lcd_ack),
    .vga_req(vga_req), .vga_addr(chan_addr[2]), .vga_gnt(vga_gnt), .vga_ack(vga_ack),
    .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_beat(mem_beat), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0;
  int log_ch [32];
  int log_n = 0;
  int ackn [3];
  int gcount [3];
  int req_cycles = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // back end: one beat per cycle, or every other cycle in gap mode
  always @(negedge clk) begin
    tog <= ~tog;
    mem_beat <= mem_req && (!gap_mode || tog);
  end
  always @(posedge clk)
    if (!rst_n) bcnt <= 0;
    else if (mem_beat) bcnt <= bcnt + 3'd1;
  assign mem_rdata = mem_addr[DW-1:0] + DW'(bcnt);

  // monitor, mid-cycle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int ch;
      ch = -1;
      if (sys_gnt) gcount[0]++;
      if (lcd_gnt) gcount[1]++;
      if (vga_gnt) gcount[2]++;
      if (mem_req) req_cycles++;
      if (sys_gnt && sys_slow) chk(0, "R7 slow cycle granted", 1, 0);
      if (!mem_beat && (sys_ack || lcd_ack || vga_ack))
        chk(0, "R9 ack without beat", 1, 0);
      if (mem_beat && mem_req) begin
        chk($countones({sys_ack, lcd_ack, vga_ack}) == 1, "R5 one ack per beat",
            $countones({sys_ack, lcd_ack, vga_ack}), 1);
        if (sys_ack) ch = 0;
        if (lcd_ack) ch = 1;
        if (vga_ack) ch = 2;
        if (ch >= 0) begin
          chk(rd_data == chan_addr[ch][DW-1:0] + DW'(bcnt), "R5 data",
              int'(rd_data), int'(chan_addr[ch][DW-1:0] + DW'(bcnt)));
          chk(mem_addr == chan_addr[ch], "R6 address", int'(mem_addr), int'(chan_addr[ch]));
          ackn[ch]++;
          if (bcnt == 0) pend[ch]--;
          if (bcnt == 7 && log_n < 32) begin
            log_ch[log_n] = ch;
            log_n++;
          end
        end
      end
    end
  end

  task automatic clear();
    log_n = 0;
    req_cycles = 0;
    for (int i = 0; i < 3; i++) begin
      ackn[i] = 0;
      gcount[i] = 0;
    end
  endtask

  task automatic wait_done(input string rq);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((pend[0] > 0 || pend[1] > 0 || pend[2] > 0 || mem_req) && n < 600);
    chk(n < 600, {rq, " timeout"}, n, 600);
  endtask

  task automatic check_log(input int exp[32], input int n, input string rq);
    chk(log_n == n, {rq, " burst count"}, log_n, n);
    for (int i = 0; i < n && i < log_n; i++)
      chk(log_ch[i] == exp[i], {rq, " order"}, log_ch[i], exp[i]);
  endtask

  int watchdog = 0;
  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", watchdog);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int exp [32];
    int n;
    for (int i = 0; i < 3; i++) pend[i] = 0;
    chan_addr[0] = 20'h1_2340;
    chan_addr[1] = 20'h0_8000;
    chan_addr[2] = 20'hA_0100;
    clear();
    repeat (3) @(negedge clk);
    #1;
    chk(!sys_gnt && !lcd_gnt && !vga_gnt, "R1 reset grants", {sys_gnt, lcd_gnt, vga_gnt}, 0);
    chk(!mem_req, "R1 reset mem_req", mem_req, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!mem_req, "R1 after reset", mem_req, 0);

    // R2 idle
    clear();
    repeat (10) @(negedge clk);
    chk(req_cycles == 0, "R2 idle", req_cycles, 0);

    // R3 sweep over 0..2 bursts per requester, raised together
    for (int ns = 0; ns < 3; ns++)
      for (int nl = 0; nl < 3; nl++)
        for (int nv = 0; nv < 3; nv++) begin
          clear();
          @(negedge clk);
          pend[0] = ns; pend[1] = nl; pend[2] = nv;
          wait_done("R3");
          n = 0;
          for (int i = 0; i < nl; i++) exp[n++] = 1;
          for (int i = 0; i < nv; i++) exp[n++] = 2;
          for (int i = 0; i < ns; i++) exp[n++] = 0;
          check_log(exp, n, "R3");
          chk(ackn[0] + ackn[1] + ackn[2] == 8 * n, "R4 beats", ackn[0] + ackn[1] + ackn[2], 8 * n);
        end

    // R4 no preemption: video arrives mid system burst
    clear();
    @(negedge clk);
    pend[0] = 1;
    repeat (4) @(negedge clk);
    pend[1] = 1;
    pend[2] = 1;
    wait_done("R4");
    exp[0] = 0; exp[1] = 1; exp[2] = 2;
    check_log(exp, 3, "R4");
    chk(gcount[0] == 8, "R4 system burst held", gcount[0], 8);

    // R8 back-to-back LCD bursts
    clear();
    @(negedge clk);
    pend[1] = 2;
    wait_done("R8");
    chk(gcount[1] == 16, "R8 no idle slot", gcount[1], 16);
    chk(ackn[1] == 16, "R8 acks", ackn[1], 16);

    // R9 gaps in beats
    clear();
    gap_mode = 1;
    @(negedge clk);
    pend[0] = 1; pend[1] = 1; pend[2] = 1;
    wait_done("R9");
    exp[0] = 1; exp[1] = 2; exp[2] = 0;
    check_log(exp, 3, "R9");
    chk(ackn[0] == 8 && ackn[1] == 8 && ackn[2] == 8, "R9 acks per burst", ackn[1], 8);
    chk(gcount[1] > 8, "R9 gaps stretch burst", gcount[1], 9);
    gap_mode = 0;

    // R7 slow system cycle held while video runs
    clear();
    @(negedge clk);
    sys_slow = 1;
    pend[1] = 2;
    pend[2] = 1;
    wait_done("R7");
    repeat (20) @(negedge clk);
    exp[0] = 1; exp[1] = 1; exp[2] = 2;
    check_log(exp, 3, "R7");
    chk(ackn[0] == 0, "R7 no system acks", ackn[0], 0);
    chk(req_cycles == 24, "R7 port idle after video", req_cycles, 24);
    sys_slow = 0;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule